// File: doc/BRIEF.md
# CGMS Serial Word Assembler

This block builds the 20-bit copy-generation-management word that goes on a chosen line of an interlaced NTSC picture, and sends it out one bit at a time. A line trigger starts a transmission. The block first checks the video standard and the enable for the current field. If the line is allowed, it captures the fourteen payload bits and a six-bit check sequence. It then shifts the word out with the most significant bit first, holding each bit for a fixed number of clocks.

The check sequence comes from one of two sources, chosen by a mode input at the moment of capture. In one mode the block computes a CRC over the payload. In the other it forwards a six-bit value taken from a register. Odd fields and even fields have separate enables. When the standard is not NTSC, no word is ever sent. A trigger that arrives during a transmission is dropped.

Top module: `cgms_tx`

## Requirements
- R1: While reset is held and straight after it, `busy`, `bitValid` and `serOut` are all 0.
- R2: A word is 20 bits sent in this order: `dataBits[13]` down to `dataBits[0]`, then the six check bits from `chk[5]` down to `chk[0]`. The 4-bit register field `dataBits[3:0]` makes up the last four payload bits.
- R3: With `crcInternal`=1, the check bits are the CRC with generator x^6+x+1 and register preset 6'b111111, taken over the 14 payload bits in send order.
- R4: With `crcInternal`=0, the check bits are `crcReg` unchanged, with `crcReg[5]` sent first.
- R5: Each bit stays on `serOut` for exactly BIT_CLKS clocks. `bitValid` is high only in the first clock of each bit. `serOut` is 0 whenever `busy` is 0.
- R6: An accepted trigger sets `busy`, and raises the first `bitValid`, in the cycle after the sampling edge. `busy` then stays high for exactly 20*BIT_CLKS cycles.
- R7: With `fieldOdd`=1 a word is sent only if `oddEn`=1. With `fieldOdd`=0 a word is sent only if `evenEn`=1.
- R8: With `isNtsc`=0 a trigger starts nothing, whatever the field enables are.
- R9: A trigger during `busy` is ignored. The running word is neither restarted nor lengthened, and no extra word follows it.
- R10: All word inputs are sampled at the accepted trigger. Changing them during a transmission leaves that word unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineTrig | input | 1 | Start request for the current line |
| fieldOdd | input | 1 | 1 = odd field, 0 = even field |
| oddEn | input | 1 | Allow the word on odd fields |
| evenEn | input | 1 | Allow the word on even fields |
| isNtsc | input | 1 | 1 = NTSC standard |
| crcInternal | input | 1 | 1 = computed check bits, 0 = register value |
| dataBits | input | 14 | Payload bits; bit 13 is sent first |
| crcReg | input | 6 | Check bits forwarded when `crcInternal`=0 |
| serOut | output | 1 | Serial data |
| bitValid | output | 1 | Marks the first clock of each bit |
| busy | output | 1 | A transmission is running |

## Verification
The hardest case to reach from the ports is a second trigger that lands in the middle of a word, together with changed payload, mode and check inputs. The stimulus starts a word and waits part way through it. It then pulses the trigger with a fresh set of inputs and leaves them changed. The scoreboard expects the first word intact, a `busy` span of exactly the nominal length, and no second word. The CRC is compared against a polynomial-division model over many random payloads, alongside fixed all-zero and all-one payloads.

// File: rtl/cgms_pkg.sv
package cgms_pkg;
  localparam int CGMS_DATA_W = 14;
  localparam int CGMS_CRC_W  = 6;
  localparam logic [CGMS_CRC_W-1:0] CGMS_POLY = 6'b000011;
  localparam logic [CGMS_CRC_W-1:0] CGMS_INIT = 6'b111111;

  typedef struct packed {
    logic load;
    logic shift;
  } cgmsStrobe_t;
endpackage

// File: rtl/cgms_crc.sv
module cgms_crc #(
  parameter int DATA_W = 14,
  parameter int CRC_W  = 6,
  parameter logic [CRC_W-1:0] POLY = 6'b000011,
  parameter logic [CRC_W-1:0] INIT = 6'b111111
) (
  input  logic [DATA_W-1:0] data,
  output logic [CRC_W-1:0]  crc
);
  logic [CRC_W-1:0] acc;
  logic fb;

  always_comb begin
    acc = INIT;
    fb  = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb  = data[i] ^ acc[CRC_W-1];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc = acc;
  end
endmodule

// File: rtl/cgms_ctrl.sv
module cgms_ctrl
  import cgms_pkg::*;
#(
  parameter int BIT_CLKS = 4,
  parameter int WORD_W   = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineTrig,
  input  logic        fieldOdd,
  input  logic        oddEn,
  input  logic        evenEn,
  input  logic        isNtsc,
  output cgmsStrobe_t strobe,
  output logic        busy,
  output logic        bitValid
);
  localparam int CLK_W = $clog2(BIT_CLKS + 1);
  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam logic [CLK_W-1:0] CLK_LAST = CLK_W'(BIT_CLKS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  logic [CLK_W-1:0] clkCnt;
  logic [BIT_W-1:0] bitCnt;
  logic fieldOk, start, bitEnd, lastTick;

  assign fieldOk  = isNtsc && (fieldOdd ? oddEn : evenEn);
  assign start    = lineTrig && !busy && fieldOk;
  assign bitEnd   = busy && (clkCnt == CLK_LAST);
  assign lastTick = bitEnd && (bitCnt == BIT_LAST);

  always_comb begin
    strobe.load  = start;
    strobe.shift = bitEnd && !lastTick;
  end

  assign bitValid = busy && (clkCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      clkCnt <= '0;
      bitCnt <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      clkCnt <= '0;
      bitCnt <= '0;
    end else if (busy) begin
      if (bitEnd) begin
        clkCnt <= '0;
        if (lastTick) busy <= 1'b0;
        else          bitCnt <= bitCnt + 1'b1;
      end else begin
        clkCnt <= clkCnt + 1'b1;
      end
    end
  end

  a_r8_pal_ignored: assert property (@(posedge clk) disable iff (!rstN)
    lineTrig && !busy && !isNtsc |=> !busy);
  a_r7_field_gate: assert property (@(posedge clk) disable iff (!rstN)
    lineTrig && !busy && !(fieldOdd ? oddEn : evenEn) |=> !busy);
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    busy && lineTrig && !lastTick |=> busy && !(bitCnt == '0 && clkCnt == '0));
  a_r6_first_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> bitValid);
  a_r6_full_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(bitCnt) == BIT_LAST);
endmodule

// File: rtl/cgms_dp.sv
module cgms_dp
  import cgms_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int CRC_W  = 6,
  parameter logic [CRC_W-1:0] POLY = 6'b000011,
  parameter logic [CRC_W-1:0] INIT = 6'b111111
) (
  input  logic              clk,
  input  logic              rstN,
  input  cgmsStrobe_t       strobe,
  input  logic              busy,
  input  logic              crcInternal,
  input  logic [DATA_W-1:0] dataBits,
  input  logic [CRC_W-1:0]  crcReg,
  output logic              serOut
);
  localparam int WORD_W = DATA_W + CRC_W;

  logic [WORD_W-1:0] shReg;
  logic [CRC_W-1:0]  crcVal, chkSel;

  cgms_crc #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY), .INIT(INIT)) u_crc (
    .data(dataBits),
    .crc (crcVal)
  );

  assign chkSel = crcInternal ? crcVal : crcReg;

  always_ff @(posedge clk) begin
    if (!rstN)             shReg <= '0;
    else if (strobe.load)  shReg <= {dataBits, chkSel};
    else if (strobe.shift) shReg <= {shReg[WORD_W-2:0], 1'b0};
  end

  assign serOut = busy && shReg[WORD_W-1];

  a_r4_passthru: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && !crcInternal |=> shReg[CRC_W-1:0] == $past(crcReg));
  a_r3_crc_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load && crcInternal |=> shReg[CRC_W-1:0] == $past(crcVal));
  a_r2_payload_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> shReg[WORD_W-1:CRC_W] == $past(dataBits));
endmodule

// File: rtl/cgms_tx.sv
module cgms_tx
  import cgms_pkg::*;
#(
  parameter int BIT_CLKS = 4,
  parameter int DATA_W   = CGMS_DATA_W,
  parameter int CRC_W    = CGMS_CRC_W,
  parameter logic [CRC_W-1:0] POLY = CGMS_POLY,
  parameter logic [CRC_W-1:0] INIT = CGMS_INIT
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineTrig,
  input  logic              fieldOdd,
  input  logic              oddEn,
  input  logic              evenEn,
  input  logic              isNtsc,
  input  logic              crcInternal,
  input  logic [DATA_W-1:0] dataBits,
  input  logic [CRC_W-1:0]  crcReg,
  output logic              serOut,
  output logic              bitValid,
  output logic              busy
);
  localparam int WORD_W = DATA_W + CRC_W;

  cgmsStrobe_t strobe;

  cgms_ctrl #(.BIT_CLKS(BIT_CLKS), .WORD_W(WORD_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .lineTrig(lineTrig),
    .fieldOdd(fieldOdd),
    .oddEn   (oddEn),
    .evenEn  (evenEn),
    .isNtsc  (isNtsc),
    .strobe  (strobe),
    .busy    (busy),
    .bitValid(bitValid)
  );

  cgms_dp #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY), .INIT(INIT)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busy       (busy),
    .crcInternal(crcInternal),
    .dataBits   (dataBits),
    .crcReg     (crcReg),
    .serOut     (serOut)
  );

  a_r5_valid_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> busy);
  a_r5_bit_hold: assert property (@(posedge clk) disable iff (!rstN)
    busy && !bitValid |-> $stable(serOut));
endmodule

// File: tb/cgms_tx_bench.sv
module cgms_tx_bench;
  localparam int BC = 4;

  logic clk = 1'b0, rstN = 1'b0, lineTrig = 1'b0;
  logic fieldOdd = 1'b0, oddEn = 1'b0, evenEn = 1'b0, isNtsc = 1'b0, crcInternal = 1'b0;
  logic [13:0] dataBits = '0;
  logic [5:0]  crcReg = '0;
  logic serOut, bitValid, busy;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;
  bit expQ[$];
  string tagQ[$];

  always #5 clk = ~clk;

  cgms_tx #(.BIT_CLKS(BC)) u_cgms_tx (
    .clk(clk), .rstN(rstN), .lineTrig(lineTrig), .fieldOdd(fieldOdd),
    .oddEn(oddEn), .evenEn(evenEn), .isNtsc(isNtsc), .crcInternal(crcInternal),
    .dataBits(dataBits), .crcReg(crcReg), .serOut(serOut),
    .bitValid(bitValid), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // check bits by long division; the all-ones preset is folded into the top six message bits
  function automatic logic [5:0] refCrc(input logic [13:0] d);
    logic [19:0] m;
    m = {d ^ 14'h3F00, 6'b0};
    for (int i = 19; i >= 6; i--)
      if (m[i]) m[i -: 7] = m[i -: 7] ^ 7'b1000011;
    return m[5:0];
  endfunction

  // scoreboard monitor
  int busyRun = 0, holdCnt = 0;
  bit curBit = 1'b0, prevBusy = 1'b0;
  always @(negedge clk) begin
    if (!rstN) begin
      busyRun = 0; holdCnt = 0; prevBusy = 1'b0;
    end else begin
      if (busy) busyRun++;
      if (bitValid) begin
        if (holdCnt != 0) chk(holdCnt == BC, "R5 bit length", holdCnt, BC);
        holdCnt = 1;
        curBit = serOut;
        if (expQ.size() == 0) chk(1'b0, "R9 unexpected bit", 1, 0);
        else begin
          bit e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          chk(serOut == e, t, int'(serOut), int'(e));
        end
      end else if (busy) begin
        holdCnt++;
        if (serOut !== curBit) chk(1'b0, "R5 bit changed in period", int'(serOut), int'(curBit));
      end
      if (!busy && prevBusy) begin
        chk(busyRun == 20 * BC, "R6 busy length", busyRun, 20 * BC);
        chk(serOut == 1'b0, "R5 idle serOut", int'(serOut), 0);
        busyRun = 0;
        holdCnt = 0;
      end
      prevBusy = busy;
    end
  end

  task automatic pushWord(input logic [13:0] d, input bit mode, input logic [5:0] r);
    logic [5:0] c;
    c = mode ? refCrc(d) : r;
    for (int i = 13; i >= 0; i--) begin expQ.push_back(d[i]); tagQ.push_back("R2 payload bit"); end
    for (int i = 5; i >= 0; i--) begin
      expQ.push_back(c[i]);
      tagQ.push_back(mode ? "R3 crc bit" : "R4 pass-through bit");
    end
  endtask

  task automatic sendFrame(input logic [13:0] d, input bit mode, input logic [5:0] r,
                           input bit fOdd, input bit oEn, input bit eEn, input bit ntsc,
                           input string tag, input bit waitIdle);
    bit go;
    go = ntsc && (fOdd ? oEn : eEn);
    @(posedge clk); #1;
    dataBits = d; crcInternal = mode; crcReg = r;
    fieldOdd = fOdd; oddEn = oEn; evenEn = eEn; isNtsc = ntsc; lineTrig = 1'b1;
    @(posedge clk); #1;
    lineTrig = 1'b0;
    if (go) pushWord(d, mode, r);
    @(negedge clk);
    chk(busy == go, {tag, " busy after trigger"}, int'(busy), int'(go));
    chk(bitValid == go, {tag, " first strobe"}, int'(bitValid), int'(go));
    if (waitIdle) while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(bitValid == 1'b0, "R1 bitValid in reset", int'(bitValid), 0);
    chk(serOut == 1'b0, "R1 serOut in reset", int'(serOut), 0);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && bitValid == 1'b0, "R1 idle after reset", int'(busy), 0);

    sendFrame(14'h0000, 1'b1, 6'h00, 1'b1, 1'b1, 1'b0, 1'b1, "R6 R3 zeros", 1'b1);
    sendFrame(14'h3FFF, 1'b1, 6'h00, 1'b0, 1'b0, 1'b1, 1'b1, "R6 R3 ones", 1'b1);
    sendFrame(14'h2A5C, 1'b0, 6'h2A, 1'b1, 1'b1, 1'b1, 1'b1, "R4 pass", 1'b1);
    sendFrame(14'h0009, 1'b0, 6'h15, 1'b0, 1'b1, 1'b1, 1'b1, "R4 pass", 1'b1);
    for (int k = 0; k < 24; k++)
      sendFrame(14'($urandom), 1'b1, 6'($urandom), 1'($urandom), 1'b1, 1'b1, 1'b1, "R3 random", 1'b1);

    sendFrame(14'h1111, 1'b1, 6'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R7 odd disabled", 1'b1);
    sendFrame(14'h2222, 1'b1, 6'h00, 1'b0, 1'b1, 1'b0, 1'b1, "R7 even disabled", 1'b1);
    sendFrame(14'h0F0F, 1'b1, 6'h00, 1'b1, 1'b1, 1'b1, 1'b0, "R8 not ntsc odd", 1'b1);
    sendFrame(14'h0F0F, 1'b1, 6'h00, 1'b0, 1'b1, 1'b1, 1'b0, "R8 not ntsc even", 1'b1);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R7 R8 nothing started", int'(busy), 0);

    // retrigger mid-word with different inputs
    sendFrame(14'h15A3, 1'b0, 6'h33, 1'b1, 1'b1, 1'b1, 1'b1, "R9 first word", 1'b0);
    repeat (10) @(posedge clk);
    #1;
    dataBits = 14'h2C4B; crcInternal = 1'b1; crcReg = 6'h0C; lineTrig = 1'b1;
    @(posedge clk); #1 lineTrig = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1, "R9 still busy after retrigger", int'(busy), 1);
    while (busy) @(negedge clk);
    repeat (2 * BC) @(negedge clk);
    chk(busy == 1'b0, "R9 no second word", int'(busy), 0);
    chk(expQ.size() == 0, "R10 word bits all consumed", expQ.size(), 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule